// File: doc/BRIEF.md
# Two-Cycle DRAM Command Decoder

This block sits behind the command/address pins of a DRAM device model or a memory-side monitor. It watches a 14-bit command/address bus (`ca`) qualified by an active-low select (`cs_n`). It classifies the opcode that opens each command, and for commands that carry an address it joins the following bus cycle into one 28-bit word. Each recognised command produces a single-cycle pulse on `cmd_valid`, together with the decoded fields. An opcode that matches no command produces a single-cycle pulse on `cmd_illegal` and is otherwise dropped.

The control is a two-state machine. ST_FIRST is the reset state, and in it the block waits for and classifies an opening cycle. ST_SECOND is entered from ST_FIRST when a two-cycle opcode is accepted (transition "accept-long"). It returns to ST_FIRST unconditionally after one clock (transition "complete"). Every other ST_FIRST cycle loops back to ST_FIRST: an idle cycle, a one-cycle command or an illegal opcode. Bits are named `ca[0]` upward. A prefix "1,0,1,1,0" means ca[0]=1, ca[1]=0, ca[2]=1, ca[3]=1, ca[4]=0. In this document, "first" is the opening cycle's `ca` and "second" is the following cycle's `ca`.

Top module: `cac_decoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `cmd_valid` and `cmd_illegal` are 0 and `cmd_code` is 0.
- R2: A cycle in ST_FIRST with `cs_n` high starts nothing: `cmd_valid` and `cmd_illegal` are 0 one clock later.
- R3: One-cycle opcodes report their code one clock after the opening cycle. The prefixes and codes are: refresh 1,1,0,0,1 (code 7 if ca[10]=0, code 8 if ca[10]=1); precharge-group 1,1,0,1,0 (code 9 if ca[10]=0, code 10 if ca[10]=1); single-bank precharge 1,1,0,1,1 (code 11); multi-purpose 1,1,1,1,0 (code 12).
- R4: Two-cycle opcodes report their code one clock after the second cycle, and the second cycle is taken whatever the level of `cs_n`. The prefixes and codes are: activate ca[0]=0, ca[1]=0 (code 1); read 1,0,1,1,1 (code 2); write 1,0,1,1,0 (code 3); write-pattern 1,0,0,1,0,1 (code 4); mode-register write 1,0,1,0,0 (code 5); mode-register read 1,0,1,0,1 (code 6).
- R5: For codes 1 to 4, `cmd_bank`=first[7:6], `cmd_bg`=first[10:8] and `cmd_cid`={second[13], first[13:11]}. Code 11 reports bank and bank group the same way.
- R6: Activate reports `cmd_row`={second[12:0], first[5:2]}, which is a 17-bit row.
- R7: Codes 2 to 4 report `cmd_col`={second[7:0], 3'b000}, so the column is always a multiple of eight. Codes 2 and 3 report `cmd_chop`=first[5], where 0 selects the full 16-beat burst and 1 selects a chop after 8 beats.
- R8: Codes 5 and 6 report `cmd_mra`=first[12:5]. Code 12 reports `cmd_sub`=first[12:5].
- R9: Codes 7 to 11 report `cmd_cid`={first[5], first[13:11]}. Codes 8, 10 and 11 report `cmd_bank`=first[7:6]. Codes 7 and 9 report bank 0.
- R10: Any other opening opcode with `cs_n` low raises `cmd_illegal` for one cycle, with `cmd_valid` 0. The next cycle is decoded as a fresh opening cycle.
- R11: `cmd_word` is {second, first} for codes 1 to 6 and {14'b0, first} for codes 7 to 12.
- R12: Every field that a command does not define reads 0. All outputs read 0 in cycles that do not report a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select qualifying an opening cycle |
| ca | input | 14 | Command/address bus |
| cmd_valid | output | 1 | One-cycle pulse for a decoded command |
| cmd_code | output | 4 | Command code (see R3, R4) |
| cmd_bank | output | 2 | Bank |
| cmd_bg | output | 3 | Bank group |
| cmd_cid | output | 4 | Chip ID |
| cmd_row | output | 17 | Row address |
| cmd_col | output | 11 | Column address |
| cmd_mra | output | 8 | Mode-register address |
| cmd_chop | output | 1 | Burst chop select |
| cmd_sub | output | 8 | Multi-purpose sub-command |
| cmd_word | output | 28 | Assembled command word |
| cmd_illegal | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
If the phase register is stuck in or wrongly left in ST_SECOND, an opening cycle is absorbed as address data. The next command then surfaces with a wrong code or with fields taken from the wrong cycle, and this shows on the very next pulse. If the held first cycle is stale, the effect is limited to the fields of two-cycle commands, and it appears one clock after their second cycle. Random streams that mix one-cycle commands, two-cycle commands, idle cycles and illegal opcodes back to back, with random `cs_n` in the second cycle, expose these faults as soon as a command crosses them.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;
    localparam int CA_W   = 14;
    localparam int WORD_W = 2 * CA_W;
    localparam int ROW_W  = 17;
    localparam int COL_W  = 11;
    localparam int BANK_W = 2;
    localparam int BG_W   = 3;
    localparam int CID_W  = 4;
    localparam int MRA_W  = 8;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CMD_NONE    = 4'd0,
        CMD_ACT     = 4'd1,
        CMD_RD      = 4'd2,
        CMD_WR      = 4'd3,
        CMD_WRP     = 4'd4,
        CMD_MRW     = 4'd5,
        CMD_MRR     = 4'd6,
        CMD_REF_ALL = 4'd7,
        CMD_REF_SB  = 4'd8,
        CMD_PRE_ALL = 4'd9,
        CMD_PRE_SB  = 4'd10,
        CMD_PRE     = 4'd11,
        CMD_MPC     = 4'd12
    } cmd_e;

    typedef struct packed {
        cmd_e               code;
        logic [BANK_W-1:0]  bank;
        logic [BG_W-1:0]    bg;
        logic [CID_W-1:0]   cid;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [MRA_W-1:0]   mra;
        logic               chop;
        logic [MRA_W-1:0]   sub;
        logic [WORD_W-1:0]  word;
    } dec_t;
endpackage

// File: rtl/cac_opclass.sv
`timescale 1ns/1ps
module cac_opclass
    import ddr_cmd_pkg::*;
(
    input  logic [5:0] op_bits,
    input  logic       sel_bit,
    output cmd_e       kind,
    output logic       two_cyc,
    output logic       bad
);
    always_comb begin
        kind = CMD_NONE;
        bad  = 1'b0;
        unique casez (op_bits)
            6'b????00: kind = CMD_ACT;
            6'b?11101: kind = CMD_RD;
            6'b?01101: kind = CMD_WR;
            6'b101001: kind = CMD_WRP;
            6'b?00101: kind = CMD_MRW;
            6'b?10101: kind = CMD_MRR;
            6'b?10011: kind = sel_bit ? CMD_REF_SB : CMD_REF_ALL;
            6'b?01011: kind = sel_bit ? CMD_PRE_SB : CMD_PRE_ALL;
            6'b?11011: kind = CMD_PRE;
            6'b?01111: kind = CMD_MPC;
            default:   bad  = 1'b1;
        endcase
    end

    always_comb begin
        two_cyc = 1'b0;
        unique case (kind)
            CMD_ACT, CMD_RD, CMD_WR, CMD_WRP, CMD_MRW, CMD_MRR: two_cyc = 1'b1;
            default: two_cyc = 1'b0;
        endcase
    end
endmodule

// File: rtl/cac_fields.sv
`timescale 1ns/1ps
module cac_fields
    import ddr_cmd_pkg::*;
(
    input  cmd_e            kind,
    input  logic [CA_W-1:0] first,
    input  logic [CA_W-1:0] second,
    output dec_t            dec
);
    logic [BANK_W-1:0] f_bank;
    logic [BG_W-1:0]   f_bg;
    logic [2:0]        f_cid;

    assign f_bank = first[7:6];
    assign f_bg   = first[10:8];
    assign f_cid  = first[13:11];

    always_comb begin
        dec      = '0;
        dec.code = kind;
        dec.word = {second, first};
        unique case (kind)
            CMD_ACT: begin
                dec.bank = f_bank;
                dec.bg   = f_bg;
                dec.cid  = {second[13], f_cid};
                dec.row  = {second[12:0], first[5:2]};
            end
            CMD_RD, CMD_WR: begin
                dec.bank = f_bank;
                dec.bg   = f_bg;
                dec.cid  = {second[13], f_cid};
                dec.col  = {second[7:0], 3'b000};
                dec.chop = first[5];
            end
            CMD_WRP: begin
                dec.bank = f_bank;
                dec.bg   = f_bg;
                dec.cid  = {second[13], f_cid};
                dec.col  = {second[7:0], 3'b000};
            end
            CMD_MRW, CMD_MRR: dec.mra = first[12:5];
            CMD_REF_ALL, CMD_PRE_ALL: dec.cid = {first[5], f_cid};
            CMD_REF_SB, CMD_PRE_SB: begin
                dec.cid  = {first[5], f_cid};
                dec.bank = f_bank;
            end
            CMD_PRE: begin
                dec.cid  = {first[5], f_cid};
                dec.bank = f_bank;
                dec.bg   = f_bg;
            end
            CMD_MPC: dec.sub = first[12:5];
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/cac_decoder.sv
`timescale 1ns/1ps
module cac_decoder
    import ddr_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [CA_W-1:0]   ca,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [BG_W-1:0]   cmd_bg,
    output logic [CID_W-1:0]  cmd_cid,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [MRA_W-1:0]  cmd_mra,
    output logic              cmd_chop,
    output logic [MRA_W-1:0]  cmd_sub,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_illegal
);
    typedef enum logic {ST_FIRST, ST_SECOND} phase_e;

    phase_e          state_q, state_d;
    logic [CA_W-1:0] held_q;
    cmd_e            held_kind_q;
    cmd_e            live_kind, f_kind;
    logic            live_two, live_bad;
    logic [CA_W-1:0] f_in, s_in;
    dec_t            dec, out_q;
    logic            valid_q, illegal_q;
    logic            second_phase;

    cac_opclass u_cls (
        .op_bits (ca[5:0]),
        .sel_bit (ca[10]),
        .kind    (live_kind),
        .two_cyc (live_two),
        .bad     (live_bad)
    );

    always_comb begin
        if (state_q == ST_SECOND) begin
            f_kind = held_kind_q;
            f_in   = held_q;
            s_in   = ca;
        end else begin
            f_kind = live_kind;
            f_in   = ca;
            s_in   = '0;
        end
    end

    cac_fields u_fld (
        .kind   (f_kind),
        .first  (f_in),
        .second (s_in),
        .dec    (dec)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST:  if (!cs_n && !live_bad && live_two) state_d = ST_SECOND;
            ST_SECOND: state_d = ST_FIRST;
            default:   state_d = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FIRST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q      <= '0;
            held_kind_q <= CMD_NONE;
        end else if (state_q == ST_FIRST && !cs_n && !live_bad && live_two) begin
            held_q      <= ca;
            held_kind_q <= live_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            out_q     <= '0;
        end else begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            out_q     <= '0;
            unique case (state_q)
                ST_FIRST: begin
                    if (!cs_n) begin
                        if (live_bad) begin
                            illegal_q <= 1'b1;
                        end else if (!live_two) begin
                            valid_q <= 1'b1;
                            out_q   <= dec;
                        end
                    end
                end
                ST_SECOND: begin
                    valid_q <= 1'b1;
                    out_q   <= dec;
                end
                default: ;
            endcase
        end
    end

    assign second_phase = (state_q == ST_SECOND);

    assign cmd_valid   = valid_q;
    assign cmd_illegal = illegal_q;
    assign cmd_code    = out_q.code;
    assign cmd_bank    = out_q.bank;
    assign cmd_bg      = out_q.bg;
    assign cmd_cid     = out_q.cid;
    assign cmd_row     = out_q.row;
    assign cmd_col     = out_q.col;
    assign cmd_mra     = out_q.mra;
    assign cmd_chop    = out_q.chop;
    assign cmd_sub     = out_q.sub;
    assign cmd_word    = out_q.word;
endmodule

// File: rtl/cac_decoder_chk.sv
`timescale 1ns/1ps
module cac_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        in_second,
    input logic        valid,
    input logic        illegal,
    input logic [3:0]  code,
    input logic [10:0] col
);
    // R10
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !valid);

    // R7
    col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (col[2:0] == 3'b000));

    // R4
    second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_second |=> !in_second);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_second && cs_n) |=> (!valid && !illegal));

    // R4
    long_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && code >= 4'd1 && code <= 4'd6) |-> $past(in_second));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (code == 4'd0));
endmodule

bind cac_decoder cac_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .in_second (second_phase),
    .valid     (cmd_valid),
    .illegal   (cmd_illegal),
    .code      (cmd_code),
    .col       (cmd_col)
);

// File: tb/tb_cac_decoder.sv
`timescale 1ns/1ps
module tb_cac_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [13:0] ca = '0;
    logic        cmd_valid, cmd_chop, cmd_illegal;
    logic [3:0]  cmd_code, cmd_cid;
    logic [1:0]  cmd_bank;
    logic [2:0]  cmd_bg;
    logic [16:0] cmd_row;
    logic [10:0] cmd_col;
    logic [7:0]  cmd_mra, cmd_sub;
    logic [27:0] cmd_word;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cac_decoder dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_bg(cmd_bg), .cmd_cid(cmd_cid), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_mra(cmd_mra), .cmd_chop(cmd_chop), .cmd_sub(cmd_sub),
        .cmd_word(cmd_word), .cmd_illegal(cmd_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference opcode table written from R3/R4/R10; 15 means illegal
    function automatic logic [3:0] ref_code(input logic [13:0] f);
        if (!f[0] && !f[1]) return 4'd1;
        if (f[0] && !f[1]) begin
            if (f[2]) begin
                if (f[3] && !f[4]) return 4'd3;
                if (f[3] && f[4])  return 4'd2;
                if (!f[3] && !f[4]) return 4'd5;
                return 4'd6;
            end
            if (f[3] && !f[4] && f[5]) return 4'd4;
            return 4'd15;
        end
        if (f[0] && f[1]) begin
            if (!f[2]) begin
                if (!f[3] && f[4]) return f[10] ? 4'd8 : 4'd7;
                if (f[3] && !f[4]) return f[10] ? 4'd10 : 4'd9;
                if (f[3] && f[4])  return 4'd11;
                return 4'd15;
            end
            if (f[3] && !f[4]) return 4'd12;
            return 4'd15;
        end
        return 4'd15;
    endfunction

    task automatic check_out(input logic [13:0] f, input logic [13:0] s);
        logic [3:0] c;
        bit two, ill;
        logic [1:0] e_bank; logic [2:0] e_bg; logic [3:0] e_cid;
        logic [16:0] e_row; logic [10:0] e_col; logic [7:0] e_mra, e_sub;
        logic e_chop; logic [27:0] e_word;
        c   = ref_code(f);
        ill = (c == 4'd15);
        two = (c >= 4'd1 && c <= 4'd6);
        e_bank = (c inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd10, 4'd11}) ? f[7:6] : 2'd0;
        e_bg   = (c inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd11}) ? f[10:8] : 3'd0;
        e_cid  = (c >= 4'd1 && c <= 4'd4) ? {s[13], f[13:11]} :
                 (c >= 4'd7 && c <= 4'd11) ? {f[5], f[13:11]} : 4'd0;
        e_row  = (c == 4'd1) ? {s[12:0], f[5:2]} : 17'd0;
        e_col  = (c >= 4'd2 && c <= 4'd4) ? {s[7:0], 3'b000} : 11'd0;
        e_chop = (c == 4'd2 || c == 4'd3) ? f[5] : 1'b0;
        e_mra  = (c == 4'd5 || c == 4'd6) ? f[12:5] : 8'd0;
        e_sub  = (c == 4'd12) ? f[12:5] : 8'd0;
        e_word = ill ? 28'd0 : (two ? {s, f} : {14'd0, f});
        chk("R4",  "valid",   cmd_valid,   !ill);
        chk("R10", "illegal", cmd_illegal, ill);
        chk("R3",  "code",    cmd_code,    ill ? 4'd0 : c);
        chk("R5",  "bank",    cmd_bank,    e_bank);
        chk("R5",  "bg",      cmd_bg,      e_bg);
        chk("R9",  "cid",     cmd_cid,     e_cid);
        chk("R6",  "row",     cmd_row,     e_row);
        chk("R7",  "col",     cmd_col,     e_col);
        chk("R7",  "chop",    cmd_chop,    e_chop);
        chk("R8",  "mra",     cmd_mra,     e_mra);
        chk("R8",  "sub",     cmd_sub,     e_sub);
        chk("R11", "word",    cmd_word,    e_word);
    endtask

    // called at a negedge; returns at the negedge where the result is visible
    task automatic run_cmd(input logic [13:0] f, input logic [13:0] s, input logic cs2);
        logic [3:0] c;
        c = ref_code(f);
        cs_n = 1'b0; ca = f;
        @(negedge clk);
        if (c >= 4'd1 && c <= 4'd6) begin
            cs_n = cs2; ca = s;
            @(negedge clk);
        end
        cs_n = 1'b1;
        check_out(f, s);
    endtask

    task automatic idle_cycle();
        cs_n = 1'b1; ca = 14'($urandom);
        @(negedge clk);
        // R2: deselected opening cycle produces nothing
        chk("R2", "idle valid",   cmd_valid,   1'b0);
        chk("R2", "idle illegal", cmd_illegal, 1'b0);
        // R12: all outputs zero when no command
        chk("R12", "idle word", cmd_word, 28'd0);
    endtask

    function automatic logic [13:0] rand_cmd();
        logic [13:0] v;
        int pick;
        v = 14'($urandom);
        pick = $urandom_range(0, 11);
        case (pick)
            0: v[1:0] = 2'b00;
            1: v[4:0] = 5'b11101;
            2: v[4:0] = 5'b01101;
            3: v[5:0] = 6'b101001;
            4: v[4:0] = 5'b00101;
            5: v[4:0] = 5'b10101;
            6: v[4:0] = 5'b10011;
            7: v[4:0] = 5'b01011;
            8: v[4:0] = 5'b11011;
            9: v[4:0] = 5'b01111;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid",   cmd_valid,   1'b0);
        chk("R1", "reset illegal", cmd_illegal, 1'b0);
        chk("R1", "reset code",    cmd_code,    4'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset valid", cmd_valid, 1'b0);
        chk("R1", "post-reset code",  cmd_code,  4'd0);

        idle_cycle();
        // R4: second half taken with cs_n high (activate, full row)
        run_cmd(14'b10110111111100, 14'h3FFF, 1'b1);
        // R4: read with chop, second cycle cs_n high, looks like refresh opcode
        run_cmd(14'b01101010111101, 14'b11111110010011, 1'b1);
        // R9: refresh same bank with cid3 set
        run_cmd(14'b11110011110011, 14'd0, 1'b0);
        chk("R9", "ref sb code", cmd_code, 4'd8);
        // R9: precharge all, bank must be zero
        run_cmd(14'b00100011001011, 14'd0, 1'b0);
        chk("R9", "pre all bank", cmd_bank, 2'd0);
        // R10: illegal then immediately a valid one-cycle command
        run_cmd(14'b00000000000010, 14'd0, 1'b0);
        run_cmd(14'b01010101001111, 14'd0, 1'b0);
        // R8: mode register write, highest address, data in second word
        run_cmd(14'b01111111100101, 14'h00A5, 1'b0);
        // R7: write pattern
        run_cmd(14'b10101110101001, 14'h2081, 1'b0);
        // R12: a one-cycle command following a two-cycle one leaves no stale fields
        run_cmd(14'b00000000011011, 14'd0, 1'b0);
        idle_cycle();

        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 7) == 0) idle_cycle();
            else run_cmd(rand_cmd(), 14'($urandom), 1'($urandom));
        end
        idle_cycle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule